// File: doc/BRIEF.md
# Indirect Interrupt Register Access Router

This block sits between a processor's indirect register access path and the interrupt-file state of one hart. Each command carries a privilege level, a virtualization flag, a guest-select index, an 8-bit register select, a width flag (32 or 64 bits), write data and a write mask. The router first works out which interrupt-file page is addressed. It then decodes the register select and runs a masked read-modify-write on the target. It returns the value the register held before the write, or an error flag with zero data.

Per-page delivery-enable bits and priority thresholds are held inside the router. The per-identity pending and enable bits live in an external store. The router reaches that store through a synchronous-read word port that is 32 or 64 bits wide. The top-identity register belongs to external priority logic. The router reads the current top identity for the addressed page and issues a one-cycle claim pulse when that register is written. A parameter chooses between the machine-level and the supervisor-level configuration.

Top module: `ireg_router`

## Requirements
- R1: With MACHINE_MODE=1, only privilege 2'd3 with virtualization off is accepted, and it maps to page 0. Every other privilege/virtualization combination is an error.
- R2: With MACHINE_MODE=0, privilege 2'd1 with virtualization off maps to page 0. Privilege 2'd1 with virtualization on maps to page `cmd_guest`, which must be nonzero and below PAGES. Any other case is an error, including privilege 2'd0 or 2'd3.
- R3: The select encodings are 8'h70 delivery-enable, 8'h72 threshold, 8'h60 top-identity, 8'h80+i pending word i and 8'hC0+i enable word i (i = 0..63). Every other select value is an error.
- R4: For a pending or enable word, a 64-bit access (`cmd_wide`=1) with an odd index is an error. Any index at or above IDS/32 is also an error. Index i covers identities 32*i upward: 32 of them for a narrow access, 64 for a wide one.
- R5: A pending or enable access writes, at each bit where the mask is 1, the write-data bit into that identity's state. Bits where the mask is 0 keep their value. For a narrow access, bits 63:32 of data and mask are ignored. The store is written only when the effective mask is nonzero.
- R6: The read data is the register's value before this command's write. For a narrow access, bits 63:32 of the read data are zero.
- R7: Identity 0 of every page never becomes set, and its bit (bit 0 of word 0) always reads as 0.
- R8: Delivery-enable has only bit 0 writable, one bit per page. The threshold has THR_W writable bits per page. Both use the same masked update and return the old value in the low bits, with zeros above.
- R9: A read of top-identity returns `top_id` for the addressed page, shown on `top_page`. A write with a nonzero effective mask while `top_id` is nonzero raises `top_clr` for one cycle, together with the done pulse.
- R10: An erroring command changes no state and writes nothing to the store. It returns `rsp_err`=1 and zero read data.
- R11: A command accepted at a clock edge while the router is idle raises `rsp_done` for one cycle after the third edge, counting the accepting edge as the first. `cmd_valid` is ignored while a command is in flight.
- R12: Synchronous active-low reset clears `rsp_done`, `rsp_err`, `rsp_rdata`, `top_clr` and all delivery-enable and threshold state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, taken when idle |
| cmd_priv | input | 2 | Privilege level (0 user, 1 supervisor, 3 machine) |
| cmd_virt | input | 1 | Virtualization flag |
| cmd_guest | input | GI_W | Guest page select |
| cmd_sel | input | 8 | Register select |
| cmd_wide | input | 1 | 1 = 64-bit access, 0 = 32-bit |
| cmd_wdata | input | 64 | Write data |
| cmd_wmask | input | 64 | Write mask, 1 = bit is written |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Command was rejected |
| rsp_rdata | output | 64 | Old register value, zero on error |
| st_rd_en | output | 1 | Store read request, data due next cycle |
| st_wr_en | output | 1 | Store write request |
| st_kind_en | output | 1 | 1 = enable bits, 0 = pending bits |
| st_page | output | PG_W | Store page |
| st_slot | output | SLOT_W | 32-bit slot index within the page |
| st_wide | output | 1 | Store access spans two slots |
| st_wdata | output | 64 | Merged write bits |
| st_rdata | input | 64 | Store read bits, one cycle after st_rd_en |
| top_page | output | PG_W | Page whose top identity is requested |
| top_id | input | THR_W | Current top identity of top_page |
| top_clr | output | 1 | Claim pulse for the top identity |

## Verification
The main function is driven with narrow and wide words using partial masks and full masks. This separates a correct per-bit merge from a whole-word overwrite, and shows whether narrow accesses leak into the upper half. Back-to-back write then read pairs on the same register show whether read data is the pre-write value. Guest-routed accesses to one page are followed by a read of page 0, which exposes page misrouting. Each error class (bad privilege, guest 0, guest out of range, undecoded select, odd wide index, index out of range) is followed by a read-back of the register it could have hit. That distinguishes a rejected command from one that was only flagged.

// File: rtl/ireg_pkg.sv
// Package: shared encodings for the indirect register access router.
// Assumes: select values and privilege codes are fixed by the requester side.
package ireg_pkg;
    localparam int WORD_W  = 64;
    localparam int SLICE_W = 32;

    localparam logic [1:0] PRIV_USER  = 2'd0;
    localparam logic [1:0] PRIV_SUPER = 2'd1;
    localparam logic [1:0] PRIV_MACH  = 2'd3;

    localparam logic [7:0] SEL_DLV = 8'h70;
    localparam logic [7:0] SEL_THR = 8'h72;
    localparam logic [7:0] SEL_TOP = 8'h60;
    localparam logic [1:0] GRP_PEND = 2'b10;
    localparam logic [1:0] GRP_EN   = 2'b11;

    typedef enum logic [2:0] {
        TGT_NONE, TGT_DLV, TGT_THR, TGT_TOP, TGT_PEND, TGT_EN
    } tgt_e;

    typedef enum logic [1:0] {
        PH_IDLE, PH_FETCH, PH_COMMIT
    } phase_e;
endpackage

// File: rtl/ireg_page_sel.sv
// Module: ireg_page_sel
// Maps privilege, virtualization flag and guest index to an interrupt-file
// page, or flags the request as illegal. Purely combinational.
// Assumes: GI_W >= PG_W; in machine configuration only page 0 exists.
module ireg_page_sel
    import ireg_pkg::*;
#(
    parameter int PAGES        = 4,
    parameter int GI_W         = 6,
    parameter int PG_W         = 2,
    parameter bit MACHINE_MODE = 1'b0
) (
    input  logic [1:0]      priv,
    input  logic            virt,
    input  logic [GI_W-1:0] guest,
    output logic [PG_W-1:0] page,
    output logic            bad
);
    generate
        if (MACHINE_MODE) begin : g_mach
            // Machine configuration: a single page, machine level only
            always_comb begin
                page = '0;
                bad  = !((priv == PRIV_MACH) && !virt);
            end
        end else begin : g_super
            // Supervisor configuration: page 0 or a nonzero in-range guest page
            always_comb begin
                page = '0;
                bad  = 1'b1;
                if (priv == PRIV_SUPER) begin
                    if (!virt) begin
                        bad = 1'b0;
                    end else if ((guest != '0) && (int'(guest) < PAGES)) begin
                        bad  = 1'b0;
                        page = guest[PG_W-1:0];
                    end
                end
            end
        end
    endgenerate
endmodule

// File: rtl/ireg_sel_decode.sv
// Module: ireg_sel_decode
// Decodes the register select into a target class and a 32-bit slot index,
// and rejects undecoded selects, odd wide indices and indices past the page.
// Assumes: IDS is a multiple of 64 and at least 64.
module ireg_sel_decode
    import ireg_pkg::*;
#(
    parameter int IDS    = 128,
    parameter int SLOT_W = 2
) (
    input  logic [7:0]        sel,
    input  logic              wide,
    output tgt_e              tgt,
    output logic [SLOT_W-1:0] slot,
    output logic              bad
);
    localparam int NSLOT = IDS / SLICE_W;

    logic [5:0] idx;
    assign idx  = sel[5:0];
    assign slot = idx[SLOT_W-1:0];

    // Classify the select and apply the width and range rules to bit words
    always_comb begin
        tgt = TGT_NONE;
        bad = 1'b0;
        if (sel == SEL_DLV)             tgt = TGT_DLV;
        else if (sel == SEL_THR)        tgt = TGT_THR;
        else if (sel == SEL_TOP)        tgt = TGT_TOP;
        else if (sel[7:6] == GRP_PEND)  tgt = TGT_PEND;
        else if (sel[7:6] == GRP_EN)    tgt = TGT_EN;
        else                            bad = 1'b1;
        if ((tgt == TGT_PEND) || (tgt == TGT_EN)) begin
            if (wide && idx[0])       bad = 1'b1;
            if (int'(idx) >= NSLOT)   bad = 1'b1;
        end
    end
endmodule

// File: rtl/ireg_bit_merge.sv
// Module: ireg_bit_merge
// Per-bit masked merge of new data into old state bits, plus the read view.
// The upper half is masked off for narrow accesses; identity 0 is forced low.
// Assumes: first_slot is set when the access starts at identity 0.
module ireg_bit_merge #(
    parameter int DW   = 64,
    parameter int HALF = 32
) (
    input  logic [DW-1:0] old_bits,
    input  logic [DW-1:0] new_bits,
    input  logic [DW-1:0] mask,
    input  logic          wide,
    input  logic          first_slot,
    output logic [DW-1:0] merged,
    output logic [DW-1:0] view
);
    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            if (i == 0) begin : g_id0
                // Identity 0 of the first slot is read-only zero
                assign merged[i] = first_slot ? 1'b0 : (mask[i] ? new_bits[i] : old_bits[i]);
                assign view[i]   = first_slot ? 1'b0 : old_bits[i];
            end else if (i < HALF) begin : g_lo
                // Low half is always part of the access
                assign merged[i] = mask[i] ? new_bits[i] : old_bits[i];
                assign view[i]   = old_bits[i];
            end else begin : g_hi
                // High half only takes part in a wide access
                assign merged[i] = wide & (mask[i] ? new_bits[i] : old_bits[i]);
                assign view[i]   = wide & old_bits[i];
            end
        end
    endgenerate
endmodule

// File: rtl/ireg_router.sv
// Module: ireg_router (top)
// Routes one indirect register command at a time to an interrupt-file page
// and register, runs a masked read-modify-write and answers after a fixed
// three-edge latency. Holds per-page delivery-enable and threshold state;
// pending/enable bits live in an external synchronous-read store.
// Assumes: st_rdata is valid the cycle after st_rd_en; top_id follows
// top_page combinationally.
module ireg_router
    import ireg_pkg::*;
#(
    parameter int PAGES        = 4,
    parameter int IDS          = 128,
    parameter int THR_W        = 11,
    parameter int GI_W         = 6,
    parameter bit MACHINE_MODE = 1'b0,
    localparam int PG_W        = (PAGES > 1) ? $clog2(PAGES) : 1,
    localparam int SLOT_W      = (IDS / SLICE_W > 1) ? $clog2(IDS / SLICE_W) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_priv,
    input  logic              cmd_virt,
    input  logic [GI_W-1:0]   cmd_guest,
    input  logic [7:0]        cmd_sel,
    input  logic              cmd_wide,
    input  logic [63:0]       cmd_wdata,
    input  logic [63:0]       cmd_wmask,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              st_rd_en,
    output logic              st_wr_en,
    output logic              st_kind_en,
    output logic [PG_W-1:0]   st_page,
    output logic [SLOT_W-1:0] st_slot,
    output logic              st_wide,
    output logic [63:0]       st_wdata,
    input  logic [63:0]       st_rdata,
    output logic [PG_W-1:0]   top_page,
    input  logic [THR_W-1:0]  top_id,
    output logic              top_clr
);
    logic [PG_W-1:0]   sel_page;
    logic              page_bad;
    tgt_e              dec_tgt;
    logic [SLOT_W-1:0] dec_slot;
    logic              dec_bad;

    ireg_page_sel #(.PAGES(PAGES), .GI_W(GI_W), .PG_W(PG_W), .MACHINE_MODE(MACHINE_MODE)) u_page (
        .priv(cmd_priv), .virt(cmd_virt), .guest(cmd_guest), .page(sel_page), .bad(page_bad)
    );

    ireg_sel_decode #(.IDS(IDS), .SLOT_W(SLOT_W)) u_dec (
        .sel(cmd_sel), .wide(cmd_wide), .tgt(dec_tgt), .slot(dec_slot), .bad(dec_bad)
    );

    phase_e            phase;
    logic              accept;
    logic [PG_W-1:0]   page_q;
    tgt_e              tgt_q;
    logic [SLOT_W-1:0] slot_q;
    logic              wide_q;
    logic [63:0]       wdata_q;
    logic [63:0]       wmask_q;
    logic              err_q;
    logic              dlv_q [PAGES];
    logic [THR_W-1:0]  thr_q [PAGES];

    assign accept = cmd_valid && (phase == PH_IDLE);

    // Three-phase sequencer: idle, store fetch, commit and respond
    always_ff @(posedge clk) begin
        if (!rst_n)                  phase <= PH_IDLE;
        else if (accept)             phase <= PH_FETCH;
        else if (phase == PH_FETCH)  phase <= PH_COMMIT;
        else                         phase <= PH_IDLE;
    end

    // Capture the decoded command on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q  <= '0;
            tgt_q   <= TGT_NONE;
            slot_q  <= '0;
            wide_q  <= 1'b0;
            wdata_q <= '0;
            wmask_q <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            page_q  <= sel_page;
            tgt_q   <= dec_tgt;
            slot_q  <= dec_slot;
            wide_q  <= cmd_wide;
            wdata_q <= cmd_wdata;
            wmask_q <= cmd_wmask;
            err_q   <= page_bad | dec_bad;
        end
    end

    logic        to_store;
    logic [63:0] mask_eff;
    logic [63:0] merged;
    logic [63:0] view;
    logic [63:0] rd_next;

    assign to_store = (tgt_q == TGT_PEND) || (tgt_q == TGT_EN);
    assign mask_eff = wide_q ? wmask_q : {32'b0, wmask_q[31:0]};

    ireg_bit_merge #(.DW(WORD_W), .HALF(SLICE_W)) u_merge (
        .old_bits(st_rdata), .new_bits(wdata_q), .mask(mask_eff), .wide(wide_q),
        .first_slot(slot_q == '0), .merged(merged), .view(view)
    );

    assign st_rd_en   = (phase == PH_FETCH) && !err_q && to_store;
    assign st_wr_en   = (phase == PH_COMMIT) && !err_q && to_store && (mask_eff != '0);
    assign st_kind_en = (tgt_q == TGT_EN);
    assign st_page    = page_q;
    assign st_slot    = slot_q;
    assign st_wide    = wide_q;
    assign st_wdata   = merged;
    assign top_page   = page_q;

    // Select the pre-write value of the addressed register
    always_comb begin
        rd_next = '0;
        if (!err_q) begin
            case (tgt_q)
                TGT_DLV:         rd_next = {{(WORD_W-1){1'b0}}, dlv_q[page_q]};
                TGT_THR:         rd_next = {{(WORD_W-THR_W){1'b0}}, thr_q[page_q]};
                TGT_TOP:         rd_next = {{(WORD_W-THR_W){1'b0}}, top_id};
                TGT_PEND, TGT_EN: rd_next = view;
                default:         rd_next = '0;
            endcase
        end
    end

    // Register the response and the claim pulse in the commit phase
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
            top_clr   <= 1'b0;
        end else begin
            rsp_done <= (phase == PH_COMMIT);
            top_clr  <= (phase == PH_COMMIT) && !err_q && (tgt_q == TGT_TOP)
                        && (mask_eff != '0) && (top_id != '0);
            if (phase == PH_COMMIT) begin
                rsp_err   <= err_q;
                rsp_rdata <= rd_next;
            end
        end
    end

    // Masked update of the per-page delivery-enable and threshold state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < PAGES; p++) begin
                dlv_q[p] <= 1'b0;
                thr_q[p] <= '0;
            end
        end else if ((phase == PH_COMMIT) && !err_q) begin
            if ((tgt_q == TGT_DLV) && mask_eff[0])
                dlv_q[page_q] <= wdata_q[0];
            if (tgt_q == TGT_THR)
                thr_q[page_q] <= (thr_q[page_q] & ~mask_eff[THR_W-1:0])
                                 | (wdata_q[THR_W-1:0] & mask_eff[THR_W-1:0]);
        end
    end

    // R11
    single_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R11
    done_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(accept, 3));
    // R10
    err_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> !$past(st_wr_en));
    // R10
    err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && rsp_err) |-> (rsp_rdata == '0));
    // R5
    write_after_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr_en |-> $past(st_rd_en));
    // R7
    id0_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_wr_en && (st_slot == '0)) |-> !st_wdata[0]);
    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_rd_en |-> (int'(st_page) < PAGES));
    // R9
    claim_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        top_clr |-> (rsp_done && !rsp_err));
endmodule

// File: tb/ireg_router_bench.sv
module ireg_router_bench;
    localparam int PAGES = 4;
    localparam int IDS   = 128;
    localparam int THR_W = 11;
    localparam int GI_W  = 6;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_priv = '0;
    logic              cmd_virt = 1'b0;
    logic [GI_W-1:0]   cmd_guest = '0;
    logic [7:0]        cmd_sel = '0;
    logic              cmd_wide = 1'b0;
    logic [63:0]       cmd_wdata = '0;
    logic [63:0]       cmd_wmask = '0;
    logic              rsp_done, rsp_err, st_rd_en, st_wr_en, st_kind_en, st_wide, top_clr;
    logic [63:0]       rsp_rdata, st_wdata;
    logic [63:0]       st_rdata = '0;
    logic [1:0]        st_page, top_page;
    logic [1:0]        st_slot;
    logic [THR_W-1:0]  top_id;

    ireg_router #(.PAGES(PAGES), .IDS(IDS), .THR_W(THR_W), .GI_W(GI_W), .MACHINE_MODE(1'b0)) u_ireg_router (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_priv(cmd_priv), .cmd_virt(cmd_virt),
        .cmd_guest(cmd_guest), .cmd_sel(cmd_sel), .cmd_wide(cmd_wide), .cmd_wdata(cmd_wdata),
        .cmd_wmask(cmd_wmask), .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .st_rd_en(st_rd_en), .st_wr_en(st_wr_en), .st_kind_en(st_kind_en), .st_page(st_page),
        .st_slot(st_slot), .st_wide(st_wide), .st_wdata(st_wdata), .st_rdata(st_rdata),
        .top_page(top_page), .top_id(top_id), .top_clr(top_clr)
    );

    // Machine-configuration instance sharing the command inputs
    logic              m_done, m_err, m_rd_en, m_wr_en, m_kind, m_wide, m_clr;
    logic [63:0]       m_rdata, m_wdata;
    logic [0:0]        m_page, m_top_page;
    logic [1:0]        m_slot;

    ireg_router #(.PAGES(1), .IDS(IDS), .THR_W(THR_W), .GI_W(GI_W), .MACHINE_MODE(1'b1)) u_ireg_router_m (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_priv(cmd_priv), .cmd_virt(cmd_virt),
        .cmd_guest(cmd_guest), .cmd_sel(cmd_sel), .cmd_wide(cmd_wide), .cmd_wdata(cmd_wdata),
        .cmd_wmask(cmd_wmask), .rsp_done(m_done), .rsp_err(m_err), .rsp_rdata(m_rdata),
        .st_rd_en(m_rd_en), .st_wr_en(m_wr_en), .st_kind_en(m_kind), .st_page(m_page),
        .st_slot(m_slot), .st_wide(m_wide), .st_wdata(m_wdata), .st_rdata(64'h0),
        .top_page(m_top_page), .top_id('0), .top_clr(m_clr)
    );

    // External store model: synchronous read, write of the merged word
    logic mem_p [PAGES][IDS];
    logic mem_e [PAGES][IDS];
    logic [THR_W-1:0] tb_top [PAGES];
    assign top_id = tb_top[top_page];

    initial begin
        for (int p = 0; p < PAGES; p++)
            for (int i = 0; i < IDS; i++) begin
                mem_p[p][i] = 1'b0;
                mem_e[p][i] = 1'b0;
            end
        tb_top[0] = 11'd5; tb_top[1] = 11'd0; tb_top[2] = 11'd9; tb_top[3] = 11'd0;
    end

    always @(posedge clk) begin
        if (st_rd_en)
            for (int b = 0; b < 64; b++) begin
                if (b < 32 || st_wide)
                    st_rdata[b] <= st_kind_en ? mem_e[st_page][int'(st_slot)*32+b]
                                              : mem_p[st_page][int'(st_slot)*32+b];
                else
                    st_rdata[b] <= 1'b0;
            end
        if (st_wr_en)
            for (int b = 0; b < 64; b++)
                if (b < 32 || st_wide) begin
                    if (st_kind_en) mem_e[st_page][int'(st_slot)*32+b] <= st_wdata[b];
                    else            mem_p[st_page][int'(st_slot)*32+b] <= st_wdata[b];
                end
    end

    // Reference state kept from the requirements
    logic ref_p [PAGES][IDS];
    logic ref_e [PAGES][IDS];
    logic ref_dlv [PAGES];
    logic [THR_W-1:0] ref_thr [PAGES];

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    logic        r_err, r_clr, rm_err;
    logic [63:0] r_rd, rm_rd;
    int          r_lat;

    // Issue one command at a negedge, wait for done, capture both instances
    task automatic run_cmd(input logic [1:0] p, input logic v, input logic [5:0] g, input logic [7:0] s,
                           input logic w, input logic [63:0] d, input logic [63:0] m);
        cmd_priv = p; cmd_virt = v; cmd_guest = g; cmd_sel = s;
        cmd_wide = w; cmd_wdata = d; cmd_wmask = m; cmd_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        cmd_valid = 1'b0;
        r_lat = 1;
        while (!rsp_done && r_lat < 10) begin
            @(posedge clk); @(negedge clk);
            r_lat++;
        end
        r_err = rsp_err; r_rd = rsp_rdata; r_clr = top_clr;
        rm_err = m_err; rm_rd = m_rdata;
    endtask

    typedef struct packed {
        logic [1:0]  priv;
        logic        virt;
        logic [5:0]  guest;
        logic [7:0]  sel;
        logic        wide;
        logic [63:0] wdata;
        logic [63:0] wmask;
        logic        xerr;
        logic [3:0]  rq;
    } vec_t;

    localparam int NV = 28;
    localparam vec_t VEC [NV] = '{
        '{2'd1,1'b0,6'd0,8'h81,1'b0,64'hFFFF0000_A5A55AF0,64'h00000000_FFFFFF00,1'b0,4'd5},  // R5 partial narrow
        '{2'd1,1'b0,6'd0,8'h81,1'b0,64'h0,64'h00000000_00000F00,1'b0,4'd6},                  // R6 old value
        '{2'd1,1'b0,6'd0,8'h82,1'b1,64'h01234567_89ABCDEF,64'hFFFFFFFF_FFFFFFFF,1'b0,4'd5},  // R5 wide
        '{2'd1,1'b0,6'd0,8'h82,1'b1,64'h0,64'h0,1'b0,4'd6},                                  // R6 wide read
        '{2'd1,1'b0,6'd0,8'h83,1'b1,64'hFFFFFFFF_FFFFFFFF,64'hFFFFFFFF_FFFFFFFF,1'b1,4'd4},  // R4 odd wide
        '{2'd1,1'b0,6'd0,8'h84,1'b0,64'hFFFFFFFF_FFFFFFFF,64'hFFFFFFFF_FFFFFFFF,1'b1,4'd4},  // R4 range
        '{2'd1,1'b0,6'd0,8'h82,1'b0,64'h0,64'h0,1'b0,4'd10},                                 // R10 unchanged
        '{2'd1,1'b0,6'd0,8'h80,1'b0,64'hFFFFFFFF,64'hFFFFFFFF,1'b0,4'd7},                    // R7 set all
        '{2'd1,1'b0,6'd0,8'h80,1'b0,64'h0,64'h0,1'b0,4'd7},                                  // R7 id0 low
        '{2'd1,1'b1,6'd2,8'hC0,1'b1,64'hDEADBEEF_00000003,64'hFFFFFFFF_FFFFFFFF,1'b0,4'd2},  // R2 guest 2
        '{2'd1,1'b1,6'd2,8'hC0,1'b1,64'h0,64'h0,1'b0,4'd2},                                  // R2 guest read
        '{2'd1,1'b0,6'd0,8'hC0,1'b1,64'h0,64'h0,1'b0,4'd2},                                  // R2 page 0 clean
        '{2'd1,1'b1,6'd0,8'hC0,1'b1,64'hFFFFFFFF_FFFFFFFF,64'hFFFFFFFF_FFFFFFFF,1'b1,4'd2},  // R2 guest 0
        '{2'd1,1'b1,6'd4,8'hC0,1'b0,64'hFFFFFFFF,64'hFFFFFFFF,1'b1,4'd2},                    // R2 guest range
        '{2'd3,1'b0,6'd0,8'hC0,1'b0,64'hFFFFFFFF,64'hFFFFFFFF,1'b1,4'd2},                    // R2 machine priv
        '{2'd0,1'b0,6'd0,8'hC0,1'b0,64'hFFFFFFFF,64'hFFFFFFFF,1'b1,4'd2},                    // R2 user priv
        '{2'd1,1'b0,6'd0,8'h71,1'b0,64'hFF,64'hFF,1'b1,4'd3},                                // R3 hole
        '{2'd1,1'b0,6'd0,8'h40,1'b0,64'hFF,64'hFF,1'b1,4'd3},                                // R3 low group
        '{2'd1,1'b0,6'd0,8'h70,1'b0,64'hFF,64'hFF,1'b0,4'd8},                                // R8 delivery
        '{2'd1,1'b0,6'd0,8'h70,1'b0,64'h0,64'h0,1'b0,4'd8},                                  // R8 delivery read
        '{2'd1,1'b0,6'd0,8'h72,1'b0,64'hFFFFFFFF,64'hFFFFFFFF,1'b0,4'd8},                    // R8 threshold
        '{2'd1,1'b0,6'd0,8'h72,1'b0,64'h0,64'h0,1'b0,4'd8},                                  // R8 threshold read
        '{2'd1,1'b1,6'd3,8'h72,1'b0,64'h123,64'hF0F,1'b0,4'd8},                              // R8 masked guest
        '{2'd1,1'b1,6'd3,8'h72,1'b0,64'h0,64'h0,1'b0,4'd8},                                  // R8 guest read
        '{2'd1,1'b0,6'd0,8'h60,1'b0,64'h0,64'h0,1'b0,4'd9},                                  // R9 top read
        '{2'd1,1'b0,6'd0,8'h60,1'b0,64'h0,64'h1,1'b0,4'd9},                                  // R9 claim
        '{2'd1,1'b1,6'd1,8'h60,1'b0,64'h0,64'h1,1'b0,4'd9},                                  // R9 no claim
        '{2'd1,1'b0,6'd0,8'hC0,1'b0,64'h0,64'h0,1'b0,4'd10}                                  // R10 page 0 intact
    };

    logic        e_err, e_clr;
    logic [63:0] e_rd;

    // Reference step: expected response and state update for one vector
    task automatic model(input vec_t t);
        int pg, base, nb;
        logic [63:0] mk;
        e_err = t.xerr; e_rd = '0; e_clr = 1'b0;
        if (!t.xerr) begin
            pg = t.virt ? int'(t.guest) : 0;
            mk = t.wide ? t.wmask : {32'h0, t.wmask[31:0]};
            if (t.sel == 8'h70) begin
                e_rd = {63'h0, ref_dlv[pg]};
                if (mk[0]) ref_dlv[pg] = t.wdata[0];
            end else if (t.sel == 8'h72) begin
                e_rd = {53'h0, ref_thr[pg]};
                ref_thr[pg] = (ref_thr[pg] & ~mk[THR_W-1:0]) | (t.wdata[THR_W-1:0] & mk[THR_W-1:0]);
            end else if (t.sel == 8'h60) begin
                e_rd = {53'h0, tb_top[pg]};
                e_clr = (mk != 0) && (tb_top[pg] != 0);
            end else begin
                base = int'(t.sel[5:0]) * 32;
                nb = t.wide ? 64 : 32;
                for (int b = 0; b < nb; b++)
                    e_rd[b] = t.sel[6] ? ref_e[pg][base+b] : ref_p[pg][base+b];
                for (int b = 0; b < nb; b++)
                    if (mk[b] && (base + b != 0)) begin
                        if (t.sel[6]) ref_e[pg][base+b] = t.wdata[b];
                        else          ref_p[pg][base+b] = t.wdata[b];
                    end
            end
        end
    endtask

    initial begin
        for (int p = 0; p < PAGES; p++) begin
            ref_dlv[p] = 1'b0; ref_thr[p] = '0;
            for (int i = 0; i < IDS; i++) begin ref_p[p][i] = 1'b0; ref_e[p][i] = 1'b0; end
        end
        repeat (4) @(negedge clk);
        // R12 outputs held low in reset
        check("R12", "done in reset", {63'h0, rsp_done}, 64'h0);
        check("R12", "err in reset", {63'h0, rsp_err}, 64'h0);
        check("R12", "rdata in reset", rsp_rdata, 64'h0);
        check("R12", "claim in reset", {63'h0, top_clr}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 threshold cleared by reset
        run_cmd(2'd1, 1'b0, 6'd0, 8'h72, 1'b0, 64'h0, 64'h0);
        check("R12", "threshold after reset", r_rd, 64'h0);

        for (int k = 0; k < NV; k++) begin
            run_cmd(VEC[k].priv, VEC[k].virt, VEC[k].guest, VEC[k].sel, VEC[k].wide, VEC[k].wdata, VEC[k].wmask);
            model(VEC[k]);
            check($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d err", k), {63'h0, r_err}, {63'h0, e_err});
            check($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d rdata", k), r_rd, e_rd);
            check($sformatf("R%0d", VEC[k].rq), $sformatf("vec %0d claim", k), {63'h0, r_clr}, {63'h0, e_clr});
            // R11 fixed latency on every command
            check("R11", $sformatf("vec %0d latency", k), 64'(r_lat), 64'd3);
        end

        // R11 commands offered while busy are ignored
        begin
            int dones;
            cmd_priv = 2'd1; cmd_virt = 1'b0; cmd_guest = '0; cmd_sel = 8'hC1;
            cmd_wide = 1'b0; cmd_wdata = '0; cmd_wmask = '0; cmd_valid = 1'b1;
            @(posedge clk); @(negedge clk);
            cmd_wdata = 64'hFFFFFFFF; cmd_wmask = 64'hFFFFFFFF;
            dones = 0;
            repeat (2) begin @(posedge clk); @(negedge clk); if (rsp_done) dones++; end
            cmd_valid = 1'b0;
            repeat (6) begin @(posedge clk); @(negedge clk); if (rsp_done) dones++; end
            check("R11", "single done while busy", 64'(dones), 64'd1);
            run_cmd(2'd1, 1'b0, 6'd0, 8'hC1, 1'b0, 64'h0, 64'h0);
            check("R11", "busy write ignored", r_rd, 64'h0);
        end

        // R1 machine configuration
        run_cmd(2'd3, 1'b0, 6'd0, 8'h70, 1'b0, 64'h1, 64'h1);
        check("R1", "machine write err", {63'h0, rm_err}, 64'h0);
        check("R1", "supervisor inst rejects machine", {63'h0, r_err}, 64'h1);
        run_cmd(2'd3, 1'b0, 6'd0, 8'h70, 1'b0, 64'h0, 64'h0);
        check("R1", "machine delivery read", rm_rd, 64'h1);
        run_cmd(2'd3, 1'b1, 6'd0, 8'h70, 1'b0, 64'h0, 64'h1);
        check("R1", "machine virt err", {63'h0, rm_err}, 64'h1);
        check("R1", "machine virt data", rm_rd, 64'h0);
        run_cmd(2'd1, 1'b0, 6'd0, 8'h70, 1'b0, 64'h0, 64'h1);
        check("R1", "machine rejects supervisor", {63'h0, rm_err}, 64'h1);
        run_cmd(2'd3, 1'b0, 6'd0, 8'h70, 1'b0, 64'h0, 64'h0);
        check("R1", "machine state kept", rm_rd, 64'h1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        wait (cyc > 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=%0d expected=<20000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule